// File: doc/BRIEF.md
# Transceiver Register Bring-Up Sequencer

This block configures a 2.4 GHz transceiver on an SPI bus after power-on, with no processor involved. Once reset is released it waits out the radio's power-up time. It then reads the status register to learn which register bank is active and, if that bank is the wrong one, flips it with the bank-swap command. Next it writes a short set of primary-bank settings and, if enabled, unlocks and programs the feature registers.

The block then moves to the secondary bank. It writes fifteen 32-bit calibration words, using the byte order that each register expects. It pulses two calibration bits in register 4, waits, and returns to the primary bank. The final bank is confirmed by a second read.

The SPI side is mode 0 and is driven by one byte engine. A divider parameter derived from the system clock sets the SCK rate. A millisecond timer with a shortenable prescaler provides the long waits. Three flags report progress: `busy` while the sequence runs, `done` when it succeeds, and `error` when a bank swap has no effect.

Top module: `rbank_boot_seq`

## Requirements
- R1: While reset is held and immediately after it, `csn` is 1, `sck` is 0, `busy` is 1, and `done` and `error` are 0.
- R2: The first `csn` fall comes no earlier than PWR_MS × CLK_PER_MS clock cycles after reset is released.
- R3: The bank check is the two-byte frame {0x07, 0xFF}. Bit 7 of the second returned byte is the active bank, where 0 means primary and 1 means secondary. On a mismatch the block sends the frame {0x50, 0x53} and repeats the read frame.
- R4: In the primary bank, each setting is sent as a two-byte frame {0x20 | addr, data}. The settings go out in this order: 0x00←0x0F, 0x02←0x01 (pipe 0 on), 0x03←0x03 (5-byte address), 0x05←0x4E (channel 78), 0x06←0x27 (bit 5 = 1 and bit 3 = 0 select 250 kbit/s).
- R5: With FEAT_EN = 1, the block sends {0x50, 0x73} after the primary settings. It then sends {0x3C, 0x01} and {0x3D, 0x06}, and only after that does it check for the secondary bank.
- R6: In the secondary bank, registers 0 to 14 are written in ascending order as five-byte frames {0x20 | n, four data bytes}. Registers 0 to 8 send the most significant byte first, and registers 9 to 14 send the least significant byte first.
- R7: After register 14, register 4 is written twice, most significant byte first. The first write has bits 26:25 set and the second has them cleared. All other bits equal the stored register-4 word.
- R8: After the second register-4 write, at least CAL_MS × CLK_PER_MS cycles pass before the next frame. That frame begins the return to the primary bank, and `done` rises only after a read shows bank 0.
- R9: If the re-read after a swap still shows the wrong bank, `error` rises. No further frame is started, and `csn` stays high.
- R10: SCK is low whenever `csn` is high. Each SCK high phase and each low phase lasts at least SCK_HALF cycles. `csn` stays high for at least GAP_CYC cycles between frames. MOSI is sampled by the device on the rising edge.
- R11: `done` and `error` hold until reset and are never both set, and `busy` is low once either is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_miso | input | 1 | Serial data from the transceiver |
| spi_csn | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the transceiver |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Configuration finished with the primary bank active |
| error | output | 1 | Bank swap had no effect; sequencer halted |

## Verification
The first chip select falls one cycle after the PWR_MS × CLK_PER_MS window that follows the reset release. Every bank decision is taken one cycle after the read frame's chip-select gap of GAP_CYC cycles has finished. `done` or `error` therefore appears a few cycles past the last `csn` rise, so the bench waits on those levels with a bounded timeout instead of counting exact cycles. Frame contents are captured when each `csn` rises and are compared afterwards against an expected frame list. Every output and SPI line is sampled on the falling clock edge, half a cycle away from the edge at which the design updates them.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam logic [7:0] CMD_WR     = 8'h20;
    localparam logic [7:0] CMD_SWAP   = 8'h50;
    localparam logic [7:0] KEY_BANK   = 8'h53;
    localparam logic [7:0] KEY_FEAT   = 8'h73;
    localparam logic [7:0] REG_STATUS = 8'h07;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam int         PRI_N      = 5;
    localparam int         FEAT_N     = 2;
    localparam int         SEC_N      = 15;
    localparam int         LAST_MSB_FIRST = 8;
    localparam int         CAL_REG    = 4;
    localparam logic [31:0] CAL_BITS  = 32'h0600_0000;

    typedef enum logic [3:0] {
        ST_PWR_ARM, ST_PWR_WAIT, ST_RD_BANK, ST_CHK_BANK, ST_PRI,
        ST_FEAT_KEY, ST_FEAT, ST_SEC, ST_CAL_SET, ST_CAL_CLR,
        ST_CAL_ARM, ST_CAL_WAIT, ST_DONE, ST_ERR
    } seq_st_e;

    typedef enum logic [1:0] {GOAL_START, GOAL_SEC, GOAL_END} goal_e;

    function automatic logic [15:0] pri_entry(input logic [4:0] i);
        case (i)
            5'd0:    pri_entry = 16'h000F;
            5'd1:    pri_entry = 16'h0201;
            5'd2:    pri_entry = 16'h0303;
            5'd3:    pri_entry = 16'h054E;
            default: pri_entry = 16'h0627;
        endcase
    endfunction

    function automatic logic [15:0] feat_entry(input logic [4:0] i);
        feat_entry = (i == 5'd0) ? 16'h1C01 : 16'h1D06;
    endfunction

    function automatic logic [31:0] sec_word(input logic [4:0] i);
        case (i)
            5'd0:    sec_word = 32'h404B_01E2;
            5'd1:    sec_word = 32'hC04B_0000;
            5'd2:    sec_word = 32'hD0FC_8C02;
            5'd3:    sec_word = 32'h9900_3941;
            5'd4:    sec_word = 32'hD99E_8621;
            5'd5:    sec_word = 32'h2406_7FA6;
            5'd12:   sec_word = 32'h0012_7300;
            5'd13:   sec_word = 32'h36B4_8000;
            5'd14:   sec_word = 32'h4120_0804;
            default: sec_word = 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/rbank_spi_byte.sv
module rbank_spi_byte #(
    parameter int SCK_HALF = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    typedef struct packed {
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic [DW-1:0] div;
        logic [2:0]    bitc;
        logic          sck;
        logic          busy;
        logic          done;
    } spi_s;

    spi_s q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (go) begin
                d.busy = 1'b1;
                d.sh   = tx;
                d.div  = '0;
                d.bitc = '0;
                d.sck  = 1'b0;
            end
        end else if (q.div == DW'(SCK_HALF - 1)) begin
            d.div = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso};
            end else begin
                d.sck = 1'b0;
                if (q.bitc == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bitc = q.bitc + 3'd1;
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.div = q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.sh[7];
    assign busy = q.busy;
    assign done = q.done;
    assign rx   = q.rx;
endmodule

// File: rtl/rbank_ms_timer.sv
module rbank_ms_timer #(
    parameter int CLK_PER_MS = 200000,
    parameter int MS_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [MS_W-1:0] ms,
    output logic            expired
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

    typedef struct packed {
        logic [PW-1:0]   pre;
        logic [MS_W-1:0] left;
        logic            run;
        logic            exp;
    } tmr_s;

    tmr_s q, d;

    always_comb begin
        d = q;
        if (arm) begin
            d.pre  = '0;
            d.left = ms;
            d.run  = 1'b1;
            d.exp  = 1'b0;
        end else if (q.run) begin
            if (q.pre == PW'(CLK_PER_MS - 1)) begin
                d.pre = '0;
                if (q.left <= MS_W'(1)) begin
                    d.run = 1'b0;
                    d.exp = 1'b1;
                end else begin
                    d.left = q.left - MS_W'(1);
                end
            end else begin
                d.pre = q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = q.exp;
endmodule

// File: rtl/rbank_boot_seq.sv
module rbank_boot_seq
    import rbank_pkg::*;
#(
    parameter int CLK_PER_MS = 200000,
    parameter int PWR_MS     = 50,
    parameter int CAL_MS     = 10,
    parameter int SCK_HALF   = 13,
    parameter int GAP_CYC    = 16,
    parameter bit FEAT_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_miso,
    output logic spi_csn,
    output logic spi_sck,
    output logic spi_mosi,
    output logic busy,
    output logic done,
    output logic error
);
    localparam int MS_W = 8;
    localparam int GW   = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_st_e         st;
        goal_e           goal;
        logic            tried;
        logic [4:0]      idx;
        logic            xact;
        logic            xgap;
        logic            issued;
        logic [2:0]      xlen;
        logic [2:0]      xpos;
        logic [4:0][7:0] xbuf;
        logic [7:0]      rxb;
        logic [GW-1:0]   gcnt;
        logic            csn;
    } seq_s;

    seq_s q, d;

    logic       spi_go, spi_busy, spi_done, tmr_arm, tmr_exp;
    logic [7:0] spi_rx;
    logic [MS_W-1:0] tmr_ms;
    logic [31:0] w;

    rbank_spi_byte #(.SCK_HALF(SCK_HALF)) u_spi (
        .clk(clk), .rst_n(rst_n), .go(spi_go), .tx(q.xbuf[q.xpos]),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .busy(spi_busy), .done(spi_done), .rx(spi_rx)
    );

    assign tmr_arm = (q.st == ST_PWR_ARM) || (q.st == ST_CAL_ARM);
    assign tmr_ms  = (q.st == ST_PWR_ARM) ? MS_W'(PWR_MS) : MS_W'(CAL_MS);

    rbank_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .arm(tmr_arm), .ms(tmr_ms), .expired(tmr_exp)
    );

    always_comb begin
        d      = q;
        spi_go = 1'b0;
        w      = sec_word(q.idx);
        if (q.xact) begin
            if (!q.xgap) begin
                if (!q.issued && !spi_busy) begin
                    spi_go   = 1'b1;
                    d.issued = 1'b1;
                end
                if (spi_done) begin
                    d.issued = 1'b0;
                    d.rxb    = spi_rx;
                    if (q.xpos == q.xlen - 3'd1) begin
                        d.xgap = 1'b1;
                        d.csn  = 1'b1;
                        d.gcnt = '0;
                    end else begin
                        d.xpos = q.xpos + 3'd1;
                    end
                end
            end else if (q.gcnt == GW'(GAP_CYC - 1)) begin
                d.xact = 1'b0;
            end else begin
                d.gcnt = q.gcnt + GW'(1);
            end
        end else begin
            // every frame load opens chip select and restarts the byte pointer
            d.xgap = 1'b0;
            d.xpos = '0;
            d.xlen = 3'd2;
            case (q.st)
                ST_PWR_ARM:  d.st = ST_PWR_WAIT;
                ST_PWR_WAIT: if (tmr_exp) begin
                    d.st   = ST_RD_BANK;
                    d.goal = GOAL_START;
                end
                ST_RD_BANK: begin
                    d.xact = 1'b1; d.csn = 1'b0;
                    d.xbuf = {24'h0, FILL_BYTE, REG_STATUS};
                    d.st   = ST_CHK_BANK;
                end
                ST_CHK_BANK: begin
                    if (q.rxb[7] == (q.goal == GOAL_SEC)) begin
                        d.tried = 1'b0;
                        d.idx   = '0;
                        case (q.goal)
                            GOAL_START: d.st = ST_PRI;
                            GOAL_SEC:   d.st = ST_SEC;
                            default:    d.st = ST_DONE;
                        endcase
                    end else if (q.tried) begin
                        d.st = ST_ERR;
                    end else begin
                        d.xact = 1'b1; d.csn = 1'b0;
                        d.xbuf = {24'h0, KEY_BANK, CMD_SWAP};
                        d.tried = 1'b1;
                        d.st    = ST_RD_BANK;
                    end
                end
                ST_PRI: begin
                    d.xact = 1'b1; d.csn = 1'b0;
                    d.xbuf = {24'h0, pri_entry(q.idx)[7:0], CMD_WR | pri_entry(q.idx)[15:8]};
                    d.idx  = q.idx + 5'd1;
                    if (q.idx == 5'(PRI_N - 1)) begin
                        d.st   = FEAT_EN ? ST_FEAT_KEY : ST_RD_BANK;
                        d.goal = GOAL_SEC;
                    end
                end
                ST_FEAT_KEY: begin
                    d.xact = 1'b1; d.csn = 1'b0;
                    d.xbuf = {24'h0, KEY_FEAT, CMD_SWAP};
                    d.idx  = '0;
                    d.st   = ST_FEAT;
                end
                ST_FEAT: begin
                    d.xact = 1'b1; d.csn = 1'b0;
                    d.xbuf = {24'h0, feat_entry(q.idx)[7:0], CMD_WR | feat_entry(q.idx)[15:8]};
                    d.idx  = q.idx + 5'd1;
                    if (q.idx == 5'(FEAT_N - 1)) d.st = ST_RD_BANK;
                end
                ST_SEC: begin
                    d.xact = 1'b1; d.csn = 1'b0; d.xlen = 3'd5;
                    if (q.idx <= 5'(LAST_MSB_FIRST))
                        d.xbuf = {w[7:0], w[15:8], w[23:16], w[31:24], CMD_WR | {3'b0, q.idx}};
                    else
                        d.xbuf = {w[31:24], w[23:16], w[15:8], w[7:0], CMD_WR | {3'b0, q.idx}};
                    d.idx = q.idx + 5'd1;
                    if (q.idx == 5'(SEC_N - 1)) d.st = ST_CAL_SET;
                end
                ST_CAL_SET, ST_CAL_CLR: begin
                    w = sec_word(5'(CAL_REG));
                    w = (q.st == ST_CAL_SET) ? (w | CAL_BITS) : (w & ~CAL_BITS);
                    d.xact = 1'b1; d.csn = 1'b0; d.xlen = 3'd5;
                    d.xbuf = {w[7:0], w[15:8], w[23:16], w[31:24], CMD_WR | 8'(CAL_REG)};
                    d.st   = (q.st == ST_CAL_SET) ? ST_CAL_CLR : ST_CAL_ARM;
                end
                ST_CAL_ARM:  d.st = ST_CAL_WAIT;
                ST_CAL_WAIT: if (tmr_exp) begin
                    d.st   = ST_RD_BANK;
                    d.goal = GOAL_END;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_PWR_ARM;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign spi_csn = q.csn;
    assign done    = (q.st == ST_DONE);
    assign error   = (q.st == ST_ERR);
    assign busy    = !(done || error);
endmodule

// File: rtl/rbank_boot_chk.sv
module rbank_boot_chk #(
    parameter int SCK_HALF = 13,
    parameter int GAP_CYC  = 16
) (
    input logic clk,
    input logic rst_n,
    input logic spi_csn,
    input logic spi_sck,
    input logic busy,
    input logic done,
    input logic error
);
    logic        sck_prev;
    int unsigned sck_run, csn_high;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            sck_run  <= 0;
            csn_high <= GAP_CYC;
        end else begin
            sck_prev <= spi_sck;
            if (spi_sck != sck_prev)   sck_run <= 1;
            else if (sck_run < SCK_HALF) sck_run <= sck_run + 1;
            if (!spi_csn)              csn_high <= 0;
            else if (csn_high < GAP_CYC) csn_high <= csn_high + 1;
        end
    end

    p_sck_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck != sck_prev) |-> (sck_run >= SCK_HALF));
    p_csn_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_csn) |-> (csn_high >= GAP_CYC));
    p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sck);
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_error_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!busy && !(done && error)));
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> spi_csn);
endmodule

bind rbank_boot_seq rbank_boot_chk #(.SCK_HALF(SCK_HALF), .GAP_CYC(GAP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .busy(busy), .done(done), .error(error)
);

// File: tb/rbank_boot_seq_bench.sv
`timescale 1ns/1ps
module rbank_boot_seq_bench;
    localparam int CPM = 20, PWR = 50, CAL = 10, HALF = 2, GAP = 16;

    // R4 primary settings {addr, data}; R5 feature words; R6 secondary words
    localparam logic [15:0] PRI_EXP [5] = '{16'h000F, 16'h0201, 16'h0303, 16'h054E, 16'h0627};
    localparam logic [15:0] FEAT_EXP [2] = '{16'h1C01, 16'h1D06};
    localparam logic [31:0] SEC_EXP [15] = '{
        32'h404B01E2, 32'hC04B0000, 32'hD0FC8C02, 32'h99003941, 32'hD99E8621,
        32'h24067FA6, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h00127300, 32'h36B48000, 32'h41200804};

    logic clk = 1'b0, rst_n = 1'b0, miso;
    logic csn, sck, mosi, busy, done, error;
    always #2.5 clk = ~clk;

    rbank_boot_seq #(.CLK_PER_MS(CPM), .PWR_MS(PWR), .CAL_MS(CAL),
                     .SCK_HALF(HALF), .GAP_CYC(GAP), .FEAT_EN(1'b1)) u_rbank_boot_seq (
        .clk(clk), .rst_n(rst_n), .spi_miso(miso), .spi_csn(csn), .spi_sck(sck),
        .spi_mosi(mosi), .busy(busy), .done(done), .error(error));

    int nchk = 0, nfail = 0;
    int cyc = 0, rst_cyc = 0;

    // transceiver model state
    logic init_bank = 1'b0, stuck = 1'b0, bank = 1'b0, csn_p = 1'b1, sck_p = 1'b0;
    logic [7:0] sh = 8'h0;
    int bpos = 0, cur_len = 0, nfr = 0, run_len = 0;
    int min_hi = 999, min_lo = 999, min_gap = 999;
    logic [7:0] fb [0:63][0:4];
    int flen [0:63], t0 [0:63], t1 [0:63];

    // expected frames
    logic [7:0] eb [0:63][0:4];
    int elen [0:63];
    int ne = 0;

    logic [7:0] resp;
    assign resp = {bank, 7'h0E};
    assign miso = csn ? 1'b0 : resp[7 - bpos];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            nfr = 0; bank = init_bank; bpos = 0; csn_p = 1'b1; sck_p = 1'b0;
            min_hi = 999; min_lo = 999; min_gap = 999; run_len = 0;
        end else begin
            if (csn_p && !csn) begin
                cur_len = 0; bpos = 0;
                if (nfr < 64) t0[nfr] = cyc;
                if (nfr > 0 && (cyc - t1[nfr-1]) < min_gap) min_gap = cyc - t1[nfr-1];
            end
            if (sck == sck_p) run_len = run_len + 1;
            else begin
                if (!csn && sck_p && run_len < min_hi) min_hi = run_len;
                if (!csn && !sck_p && cur_len + bpos > 0 && run_len < min_lo) min_lo = run_len;
                run_len = 1;
            end
            if (!csn && sck && !sck_p) begin
                sh = {sh[6:0], mosi};
                if (bpos == 7) begin
                    if (cur_len < 5 && nfr < 64) fb[nfr][cur_len] = sh;
                    cur_len = cur_len + 1; bpos = 0;
                end else bpos = bpos + 1;
            end
            if (!csn_p && csn && nfr < 64) begin
                flen[nfr] = cur_len; t1[nfr] = cyc;
                if (cur_len == 2 && fb[nfr][0] == 8'h50 && fb[nfr][1] == 8'h53 && !stuck)
                    bank = ~bank;
                nfr = nfr + 1;
            end
            csn_p = csn; sck_p = sck;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic add(input int l, input logic [7:0] b0, b1, b2, b3, b4);
        elen[ne] = l; eb[ne][0] = b0; eb[ne][1] = b1; eb[ne][2] = b2; eb[ne][3] = b3; eb[ne][4] = b4;
        ne++;
    endtask

    task automatic exp_bank(input logic want, inout logic cur);
        add(2, 8'h07, 8'hFF, 0, 0, 0);
        if (cur != want) begin
            add(2, 8'h50, 8'h53, 0, 0, 0);
            add(2, 8'h07, 8'hFF, 0, 0, 0);
            cur = want;
        end
    endtask

    task automatic build(input logic start);
        logic cur = start;
        logic [31:0] w;
        ne = 0;
        exp_bank(1'b0, cur);
        for (int i = 0; i < 5; i++) add(2, 8'h20 | PRI_EXP[i][15:8], PRI_EXP[i][7:0], 0, 0, 0);
        add(2, 8'h50, 8'h73, 0, 0, 0);
        for (int i = 0; i < 2; i++) add(2, 8'h20 | FEAT_EXP[i][15:8], FEAT_EXP[i][7:0], 0, 0, 0);
        exp_bank(1'b1, cur);
        for (int i = 0; i < 15; i++) begin
            w = SEC_EXP[i];
            if (i <= 8) add(5, 8'h20 | 8'(i), w[31:24], w[23:16], w[15:8], w[7:0]);
            else        add(5, 8'h20 | 8'(i), w[7:0], w[15:8], w[23:16], w[31:24]);
        end
        w = SEC_EXP[4] | 32'h06000000;
        add(5, 8'h24, w[31:24], w[23:16], w[15:8], w[7:0]);
        w = SEC_EXP[4] & ~32'h06000000;
        add(5, 8'h24, w[31:24], w[23:16], w[15:8], w[7:0]);
        exp_bank(1'b0, cur);
    endtask

    task automatic walk(input int upto, input string req);
        for (int f = 0; f < upto; f++) begin
            bit ok = (flen[f] == elen[f]);
            int bad = -1;
            for (int b = 0; b < elen[f]; b++) if (fb[f][b] !== eb[f][b] && bad < 0) bad = b;
            if (bad >= 0) ok = 0;
            if (bad < 0) bad = 0;
            check(ok, $sformatf("%s frame %0d byte %0d", req, f, bad), fb[f][bad], eb[f][bad]);
        end
    endtask

    task automatic run(input logic b, input logic stk);
        int wd = 0;
        init_bank = b; stuck = stk;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(csn === 1'b1 && sck === 1'b0 && busy === 1'b1 && done === 1'b0 && error === 1'b0,
              "R1 reset outputs", {csn, sck, busy, done, error}, 5'b10100);
        rst_n = 1'b1; rst_cyc = cyc;
        @(negedge clk);
        check(csn === 1'b1 && busy === 1'b1 && done === 1'b0, "R1 after release",
              {csn, busy, done}, 3'b110);
        while (!(done || error) && wd < 60000) begin @(negedge clk); wd++; end
        if (wd >= 60000) check(0, "watchdog expired", wd, 0);
    endtask

    initial begin
        // scenario A: device wakes in primary bank
        build(1'b0);
        run(1'b0, 1'b0);
        walk(ne, "R3/R4/R5/R6/R7 bank0 start");
        check(nfr == ne, "R8 frame count", nfr, ne);
        check(done === 1'b1 && error === 1'b0 && busy === 1'b0, "R11 done flags",
              {done, error, busy}, 3'b100);
        check(bank == 1'b0, "R8 ends in primary bank", bank, 0);
        check(t0[0] - rst_cyc >= PWR * CPM && t0[0] - rst_cyc <= PWR * CPM + 40,
              "R2 power-up wait", t0[0] - rst_cyc, PWR * CPM);
        check(t0[ne-3] - t1[ne-4] >= CAL * CPM, "R8 calibration wait",
              t0[ne-3] - t1[ne-4], CAL * CPM);
        check(min_hi >= HALF && min_lo >= HALF, "R10 SCK phase width", min_hi < min_lo ? min_hi : min_lo, HALF);
        check(min_gap >= GAP, "R10 CSN gap", min_gap, GAP);
        repeat (200) @(negedge clk);
        check(done === 1'b1 && nfr == ne, "R11 done holds", nfr, ne);

        // scenario B: device wakes in secondary bank
        build(1'b1);
        run(1'b1, 1'b0);
        walk(ne, "R3 bank1 start");
        check(nfr == ne && done === 1'b1, "R3 swap at start then done", nfr, ne);

        // scenario C: swap ignored at the very first check
        build(1'b1);
        run(1'b1, 1'b1);
        walk(3, "R9 stuck start");
        repeat (2000) @(negedge clk);
        check(error === 1'b1 && done === 1'b0 && busy === 1'b0, "R9 error flags",
              {error, done, busy}, 3'b100);
        check(nfr == 3 && csn === 1'b1, "R9 no frames after error", nfr, 3);

        // scenario D: swap ignored when moving to the secondary bank
        build(1'b0);
        run(1'b0, 1'b1);
        walk(12, "R5/R9 stuck at secondary switch");
        repeat (500) @(negedge clk);
        check(nfr == 12 && error === 1'b1, "R9 halt after feature frames", nfr, 12);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule